// File: doc/BRIEF.md
# Congruence Sieve Engine

The engine scans consecutive integers and reports those that satisfy a set of modular conditions all at once. Each condition lives in a ring: a residue mask of programmable length L (the modulus) where bit r set means "an integer whose offset from the run's starting value is congruent to r modulo L is acceptable". Every ring steps forward together, and the engine evaluates a window of eight consecutive candidates on every clock. At a 20 MHz clock that gives 160 million trials per second. A candidate is a hit only when every active ring accepts it in the same window.

Software loads ring masks, ring lengths and a starting value while the engine is stopped. It then pulses `start` and drains hits from a valid/ready output. Hits are only first-level solutions and may be filtered further downstream, so none may be lost. When the hit queue cannot take the hits of the current window, the engine holds its position instead of dropping them. Several engines can run side by side; `start`, `running` and the hit stream are plain enough to combine outside the block.

Back-pressure rules on the hit port: `hit_valid` stays high and `hit_index` stays stable until `hit_ready` is seen high at a clock edge. One hit is consumed per edge at most. A low `hit_ready` never drops data. It only stalls the sieve once the queue is full.

Top module: `sieve_engine`

## Requirements
- R1: After reset, `running`, `hit_valid` and `cfg_err` are 0 and `trial_count` is 0. All rings are inactive.
- R2: A `start` pulse while stopped loads `trial_count` with the stored base and sets `running` at the same edge. Every following running edge that is not stalled adds 8 to `trial_count`, wrapping modulo 2^32.
- R3: The candidate at offset d from the base is a hit exactly when, for every active ring, mask bit (d mod L) is 1. Configuration writes use `cfg_kind` 0 for a mask word: `cfg_word` w sets mask bits 32w..32w+31 from `cfg_data`. They use `cfg_kind` 1 for ring control: `cfg_data[7:0]` is the length and `cfg_data[16]` is the enable. They use `cfg_kind` 2 to load the base from `cfg_data`.
- R4: Ring lengths below 2 are taken as 2 and lengths above 128 as 128. Wrap-around is exact even when a ring shorter than the window wraps several times within one clock.
- R5: A ring whose enable is 0, or which was never enabled, never rejects a candidate.
- R6: `hit_index` equals base plus offset. Hits leave in ascending candidate order, both across the lanes of one window and across windows.
- R7: While `hit_valid` is high and `hit_ready` low, `hit_index` holds. No hit is lost. The engine stalls, with `trial_count` frozen, whenever the queue (16 entries) lacks room for the current window's hits.
- R8: A configuration write while `running` is 1 changes nothing and sets `cfg_err`. `cfg_err` clears on the next accepted `start`.
- R9: A `stop` pulse clears `running` at that edge. `trial_count` then stays frozen until the next `start`. Queued hits still drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write kind: 0 mask word, 1 ring control, 2 base |
| cfg_ring | input | 5 | Ring selected by the write |
| cfg_word | input | 2 | Mask word index for kind 0 |
| cfg_data | input | 32 | Write data |
| start | input | 1 | Begin a run from the stored base (ignored while running) |
| stop | input | 1 | End the current run |
| running | output | 1 | Engine is scanning |
| cfg_err | output | 1 | A write was attempted while running |
| trial_count | output | 32 | Value of the first candidate in the current window |
| hit_valid | output | 1 | A hit is offered |
| hit_ready | input | 1 | Consumer accepts the offered hit |
| hit_index | output | 32 | Integer value of the offered hit |

## Verification
`running` and `trial_count` take their new values at the edge that samples `start` or `stop`. The first window's hits become visible one edge later, because the window is pushed into the queue at the edge after the start edge. `cfg_err` rises at the edge that samples an illegal write. The bench drives every input a short delay after a rising edge and samples at the falling edge that follows, so each check sees exactly the edge it targets. Hit lists are compared as a whole once a run is stopped and drained: the bench rebuilds the expected list from its own copy of the masks over the candidate range that `trial_count` reports, so the check does not depend on how many stall cycles occurred.

// File: rtl/sieve_pkg.sv
package sieve_pkg;
  // kinds of configuration write
  typedef enum logic [1:0] {
    CFG_MASK = 2'd0,
    CFG_CTRL = 2'd1,
    CFG_BASE = 2'd2
  } cfg_kind_e;

  // fields of a ring-control write
  localparam int CTRL_LEN_LSB = 0;
  localparam int CTRL_LEN_W   = 8;
  localparam int CTRL_EN_BIT  = 16;
endpackage

// File: rtl/sieve_ring.sv
// One residue ring: a mask of programmable length read through a phase
// pointer that steps LANES positions per advance, modulo the length.
module sieve_ring #(
  parameter int MAX_LEN = 128,
  parameter int LANES   = 8,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mask_we,
  input  logic [$clog2(MAX_LEN/DATA_W)-1:0] mask_word,
  input  logic [DATA_W-1:0]         mask_data,
  input  logic                      ctrl_we,
  input  logic [LEN_W-1:0]          ctrl_len,
  input  logic                      ctrl_en,
  input  logic                      restart,
  input  logic                      advance,
  output logic [LANES-1:0]          lane_ok
);
  localparam int POS_W = $clog2(MAX_LEN);

  logic [MAX_LEN-1:0] mask_q;
  logic [LEN_W-1:0]   len_q;
  logic               active_q;
  logic [POS_W-1:0]   phase_q;
  logic [POS_W-1:0]   pos [LANES+1];
  logic [LEN_W-1:0]   last_pos;
  logic [LEN_W-1:0]   len_clamped;

  always_comb begin
    if (ctrl_len < LEN_W'(2))            len_clamped = LEN_W'(2);
    else if (ctrl_len > LEN_W'(MAX_LEN)) len_clamped = LEN_W'(MAX_LEN);
    else                                 len_clamped = ctrl_len;
  end

  // chain of lane positions, each one step after the previous, wrapping
  always_comb begin
    last_pos = len_q - LEN_W'(1);
    pos[0]   = phase_q;
    for (int k = 0; k < LANES; k++) begin
      if (LEN_W'(pos[k]) == last_pos) pos[k+1] = '0;
      else                            pos[k+1] = pos[k] + POS_W'(1);
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++)
      lane_ok[k] = !active_q || mask_q[pos[k]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      len_q    <= LEN_W'(2);
      active_q <= 1'b0;
      phase_q  <= '0;
    end else begin
      if (mask_we)
        mask_q[mask_word*DATA_W +: DATA_W] <= mask_data;
      if (ctrl_we) begin
        len_q    <= len_clamped;
        active_q <= ctrl_en;
      end
      if (restart)      phase_q <= '0;
      else if (advance) phase_q <= pos[LANES];
    end
  end
endmodule

// File: rtl/sieve_hit_fifo.sv
// Hit queue: takes up to LANES hits per edge in ascending lane order and
// offers one per edge. DEPTH must be a power of two and at least LANES.
module sieve_hit_fifo #(
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  req_vec,
  input  logic              push_en,
  input  logic [DATA_W-1:0] window_base,
  output logic              room,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [LVL_W-1:0]  level
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0]  level_q;
  logic [LVL_W-1:0]  n_req;
  logic [LVL_W-1:0]  rank [LANES];
  logic              pop;

  always_comb begin
    n_req = '0;
    for (int k = 0; k < LANES; k++) begin
      rank[k] = n_req;
      n_req   = n_req + LVL_W'(req_vec[k]);
    end
  end

  assign room      = ({1'b0, level_q} + {1'b0, n_req}) <= (LVL_W+1)'(DEPTH);
  assign out_valid = level_q != '0;
  assign out_data  = mem[rd_ptr_q];
  assign pop       = out_valid && out_ready;
  assign level     = level_q;

  always_ff @(posedge clk) begin
    if (push_en) begin
      for (int k = 0; k < LANES; k++)
        if (req_vec[k])
          mem[wr_ptr_q + PTR_W'(rank[k])] <= window_base + DATA_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_en) wr_ptr_q <= wr_ptr_q + PTR_W'(n_req);
      if (pop)     rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      level_q <= level_q + (push_en ? n_req : '0) - LVL_W'(pop);
    end
  end
endmodule

// File: rtl/sieve_engine.sv
// Congruence sieve engine: NUM_RINGS rings, LANES candidates per clock.
module sieve_engine #(
  parameter int NUM_RINGS = 32,
  parameter int MAX_LEN   = 128,
  parameter int LANES     = 8,
  parameter int DATA_W    = 32,
  parameter int HIT_DEPTH = 16,
  localparam int RING_W   = $clog2(NUM_RINGS),
  localparam int WIDX_W   = $clog2(MAX_LEN/DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [RING_W-1:0] cfg_ring,
  input  logic [WIDX_W-1:0] cfg_word,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              start,
  input  logic              stop,
  output logic              running,
  output logic              cfg_err,
  output logic [DATA_W-1:0] trial_count,
  output logic              hit_valid,
  input  logic              hit_ready,
  output logic [DATA_W-1:0] hit_index
);
  import sieve_pkg::*;

  localparam int LEN_W = sieve_pkg::CTRL_LEN_W;
  localparam int LVL_W = $clog2(HIT_DEPTH + 1);

  logic              running_q, err_q;
  logic [DATA_W-1:0] count_q, base_q;
  logic              cfg_ok, launch, step, room;
  logic [LANES-1:0]  lane_ok [NUM_RINGS];
  logic [LANES-1:0]  hit_vec;
  logic [LVL_W-1:0]  fifo_level;

  assign cfg_ok = cfg_we && !running_q;
  assign launch = start && !running_q;
  assign step   = running_q && !stop && room;

  for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
    logic sel;
    assign sel = cfg_ok && (cfg_ring == RING_W'(r));
    sieve_ring #(
      .MAX_LEN(MAX_LEN), .LANES(LANES), .DATA_W(DATA_W), .LEN_W(LEN_W)
    ) ring_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_we  (sel && (cfg_kind == CFG_MASK)),
      .mask_word(cfg_word),
      .mask_data(cfg_data),
      .ctrl_we  (sel && (cfg_kind == CFG_CTRL)),
      .ctrl_len (cfg_data[CTRL_LEN_LSB +: LEN_W]),
      .ctrl_en  (cfg_data[CTRL_EN_BIT]),
      .restart  (launch),
      .advance  (step),
      .lane_ok  (lane_ok[r])
    );
  end

  // first-level solution detection: wide AND across all ring windows
  always_comb begin
    hit_vec = '1;
    for (int r = 0; r < NUM_RINGS; r++)
      hit_vec = hit_vec & lane_ok[r];
  end

  sieve_hit_fifo #(
    .LANES(LANES), .DEPTH(HIT_DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)
  ) fifo_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vec    (hit_vec),
    .push_en    (step),
    .window_base(count_q),
    .room       (room),
    .out_valid  (hit_valid),
    .out_ready  (hit_ready),
    .out_data   (hit_index),
    .level      (fifo_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      err_q     <= 1'b0;
      count_q   <= '0;
      base_q    <= '0;
    end else begin
      if (cfg_ok && (cfg_kind == CFG_BASE)) base_q <= cfg_data;
      if (launch) begin
        running_q <= 1'b1;
        count_q   <= base_q;
        err_q     <= 1'b0;
      end else if (running_q) begin
        if (cfg_we) err_q <= 1'b1;
        if (stop)       running_q <= 1'b0;
        else if (room)  count_q   <= count_q + DATA_W'(LANES);
      end
    end
  end

  assign running     = running_q;
  assign cfg_err     = err_q;
  assign trial_count = count_q;
endmodule

// File: rtl/sieve_engine_chk.sv
module sieve_engine_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cfg_we,
  input logic              running,
  input logic              cfg_err,
  input logic [DATA_W-1:0] trial_count,
  input logic              hit_valid,
  input logic              hit_ready,
  input logic [DATA_W-1:0] hit_index,
  input logic [LVL_W-1:0]  fifo_level
);
  // R2: a running window either holds or moves on by exactly LANES
  a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> (trial_count == $past(trial_count)) ||
                            (trial_count == $past(trial_count) + DATA_W'(LANES)));

  // R7: an offered hit is held until taken
  a_r7_hold_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> hit_valid && $stable(hit_index));

  // R7: the queue never holds more than its depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R8: a write during a run raises the error flag
  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cfg_we) |=> cfg_err);

  // R9: a stopped engine keeps its count until restarted
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(trial_count));
endmodule

bind sieve_engine sieve_engine_chk #(
  .DATA_W(DATA_W), .LANES(LANES), .DEPTH(HIT_DEPTH), .LVL_W(LVL_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .cfg_we     (cfg_we),
  .running    (running),
  .cfg_err    (cfg_err),
  .trial_count(trial_count),
  .hit_valid  (hit_valid),
  .hit_ready  (hit_ready),
  .hit_index  (hit_index),
  .fifo_level (fifo_level)
);

// File: tb/sieve_engine_tb.sv
module sieve_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RINGS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [4:0]  cfg_ring = '0;
  logic [1:0]  cfg_word = '0;
  logic [31:0] cfg_data = '0;
  logic        start = 1'b0, stop = 1'b0, hit_ready = 1'b0;
  logic        running, cfg_err, hit_valid;
  logic [31:0] trial_count, hit_index;

  int total = 0, bad = 0;
  bit done = 0;
  bit [127:0] b_mask [RINGS];
  int unsigned b_len [RINGS];
  bit b_en [RINGS];
  logic [31:0] got [$];

  sieve_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_ring(cfg_ring), .cfg_word(cfg_word), .cfg_data(cfg_data),
    .start(start), .stop(stop), .running(running), .cfg_err(cfg_err),
    .trial_count(trial_count), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_index(hit_index)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    if (rst_n && hit_valid && hit_ready) got.push_back(hit_index);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv();
    @(posedge clk); #2;
  endtask

  task automatic cfg_write(logic [1:0] kind, int ring, int word, logic [31:0] data);
    drv();
    cfg_we = 1'b1; cfg_kind = kind; cfg_ring = 5'(ring);
    cfg_word = 2'(word); cfg_data = data;
    drv();
    cfg_we = 1'b0;
  endtask

  task automatic set_mask(int ring, bit [127:0] m);
    for (int w = 0; w < 4; w++) cfg_write(2'd0, ring, w, m[w*32 +: 32]);
    b_mask[ring] = m;
  endtask

  task automatic set_ctrl(int ring, int len, bit en);
    cfg_write(2'd1, ring, 0, (32'(en) << 16) | 32'(len & 8'hff));
    b_len[ring] = (len < 2) ? 2 : (len > 128) ? 128 : len;
    b_en[ring] = en;
  endtask

  task automatic clear_rings();
    for (int r = 0; r < RINGS; r++) set_ctrl(r, 2, 1'b0);
  endtask

  function automatic bit model_ok(int unsigned d);
    for (int r = 0; r < RINGS; r++)
      if (b_en[r] && !b_mask[r][d % b_len[r]]) return 1'b0;
    return 1'b1;
  endfunction

  // R2: start from base; checks the count and running the edge after start
  task automatic begin_run(logic [31:0] base);
    cfg_write(2'd2, 0, 0, base);
    got.delete();
    drv(); start = 1'b1;
    drv(); start = 1'b0;
    @(negedge clk);
    chk(running == 1'b1, "R2 running after start", 32'(running), 1);
    chk(trial_count == base, "R2 base loaded", trial_count, base);
  endtask

  // R9: stop, then the count must stay put; returns the final count
  task automatic end_run(output logic [31:0] final_count);
    drv(); stop = 1'b1;
    drv(); stop = 1'b0;
    @(negedge clk);
    chk(running == 1'b0, "R9 running cleared", 32'(running), 0);
    final_count = trial_count;
    repeat (4) @(negedge clk);
    chk(trial_count == final_count, "R9 count frozen", trial_count, final_count);
  endtask

  task automatic drain();
    drv(); hit_ready = 1'b1;
    repeat (60) @(negedge clk);
    chk(hit_valid == 1'b0, "R7 queue drained", 32'(hit_valid), 0);
  endtask

  // R3 R6: received list must equal the model's list over the scanned range
  task automatic compare_hits(string req, logic [31:0] base, logic [31:0] final_count);
    logic [31:0] exp_q [$];
    int unsigned n = final_count - base;
    int first_bad = -1;
    for (int unsigned d = 0; d < n; d++)
      if (model_ok(d)) exp_q.push_back(base + d);
    chk(got.size() == exp_q.size(), {req, " hit count"}, 32'(got.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      if (first_bad < 0 && got[i] != exp_q[i]) first_bad = i;
    if (first_bad >= 0)
      chk(1'b0, {req, " hit values"}, got[first_bad], exp_q[first_bad]);
    else
      chk(1'b1, {req, " hit values"}, 0, 0);
  endtask

  task automatic t_reset();
    chk(running == 1'b0, "R1 running", 32'(running), 0);
    chk(hit_valid == 1'b0, "R1 hit_valid", 32'(hit_valid), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", 32'(cfg_err), 0);
    chk(trial_count == 0, "R1 trial_count", trial_count, 0);
  endtask

  // R3: two rings, 7 and 5, accepting residues 3 and 1
  task automatic t_two_rings();
    logic [31:0] fc;
    clear_rings();
    set_mask(0, 128'h8); set_ctrl(0, 7, 1'b1);
    set_mask(1, 128'h2); set_ctrl(1, 5, 1'b1);
    drv(); hit_ready = 1'b1;
    begin_run(32'd1000);
    @(negedge clk);
    chk(trial_count == 32'd1008, "R2 advance by 8", trial_count, 32'd1008);
    repeat (40) @(negedge clk);
    end_run(fc);
    drain();
    compare_hits("R3", 32'd1000, fc);
  endtask

  // R4: length 1 clamps to 2, length 3 wraps inside one window; count wraps
  task automatic t_short_wrap();
    logic [31:0] fc;
    clear_rings();
    set_mask(0, 128'h1); set_ctrl(0, 1, 1'b1);
    set_mask(1, 128'h1); set_ctrl(1, 3, 1'b1);
    begin_run(32'hFFFF_FFF0);
    repeat (20) @(negedge clk);
    end_run(fc);
    drain();
    compare_hits("R4", 32'hFFFF_FFF0, fc);
  endtask

  // R5: disabled rings with empty masks must not veto
  task automatic t_idle_rings();
    logic [31:0] fc;
    bit [127:0] m = '0;
    clear_rings();
    m[5] = 1'b1; m[77] = 1'b1; m[127] = 1'b1;
    set_mask(0, m); set_ctrl(0, 128, 1'b1);
    set_mask(3, '0); set_ctrl(3, 4, 1'b0);
    set_mask(9, '0);
    begin_run(32'd7);
    repeat (45) @(negedge clk);
    end_run(fc);
    drain();
    compare_hits("R5", 32'd7, fc);
  endtask

  // R7 R6: every candidate hits, consumer held off, then released
  task automatic t_backpressure();
    logic [31:0] fc;
    clear_rings();
    drv(); hit_ready = 1'b0;
    begin_run(32'd50);
    @(negedge clk);
    chk(hit_valid == 1'b1, "R7 first hit one edge after window", 32'(hit_valid), 1);
    repeat (5) @(negedge clk);
    chk(trial_count == 32'd66, "R7 stalled when queue full", trial_count, 32'd66);
    chk(hit_index == 32'd50, "R6 lowest lane first", hit_index, 32'd50);
    repeat (3) @(negedge clk);
    chk(trial_count == 32'd66, "R7 stall persists", trial_count, 32'd66);
    chk(hit_index == 32'd50, "R7 offered hit held", hit_index, 32'd50);
    drv(); hit_ready = 1'b1;
    repeat (25) @(negedge clk);
    end_run(fc);
    drain();
    compare_hits("R6", 32'd50, fc);
  endtask

  // R8: a write during a run is refused and flagged
  task automatic t_cfg_locked();
    logic [31:0] fc;
    clear_rings();
    set_mask(0, '0);
    begin_run(32'd300);
    repeat (2) @(negedge clk);
    cfg_write(2'd1, 0, 0, 32'h0001_0002);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R8 error flag raised", 32'(cfg_err), 1);
    repeat (10) @(negedge clk);
    end_run(fc);
    drain();
    compare_hits("R8", 32'd300, fc);
    begin_run(32'd400);
    chk(cfg_err == 1'b0, "R8 flag cleared by start", 32'(cfg_err), 0);
    end_run(fc);
    drain();
  endtask

  initial begin
    for (int r = 0; r < RINGS; r++) begin
      b_mask[r] = '0; b_len[r] = 2; b_en[r] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    drv(); rst_n = 1'b1;
    t_two_rings();
    t_short_wrap();
    t_idle_rings();
    t_backpressure();
    t_cfg_locked();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule